// File: doc/BRIEF.md
# Dual-Rate Power-of-Two Clock Divider

This block divides a fast oscillator clock down to a main output and a second output at half the main rate. The oscillator is not a clock here. It arrives as a one-cycle enable, `vco_tick`, in the system clock domain. Each tick stands for one edge of the oscillator, so there are two ticks per oscillator period.

A 2-bit code picks the divide ratio N from 1, 2, 4 and 8. With ratio N, the main output stays high for N ticks and low for N ticks, which makes its period N oscillator periods. The half-rate output flips on every rising edge of the main output. Its edges therefore line up with the main output's edges.

Both outputs also come with complementary versions. An active-high master reset clears the dividers and parks the true outputs low and the inverted outputs high. A new divide code is picked up only when a main-output period ends, so retuning never produces a short pulse.

Top module: `dual_rate_divider`

## Requirements
- R1: With code `div_sel` = k, every high run and every low run of `fout` lasts exactly 2^k ticks. The codes map as 00 to N=1, 01 to N=2, 10 to N=4 and 11 to N=8.
- R2: `fhalf` changes only in the clock cycle in which `fout` rises, and it changes at every such rise. Its frequency is therefore exactly half that of `fout`.
- R3: Each high run of `fout` lasts as many ticks as the low run just before it, giving a 50% duty cycle for every code.
- R4: While `rst` is high, `fout` and `fhalf` are 0 and `fout_n` and `fhalf_n` are 1. Reset takes effect without waiting for a clock edge.
- R5: After `rst` falls, the dividers run from a cleared state. The first rise of `fout` comes on the 2^k-th tick, where k is the code present during reset.
- R6: A code change takes effect only where `fout` falls, which is the end of a period. The run in progress, and the high run that completes the current period, keep the old length.
- R7: `fout_n` is always the inverse of `fout`, and `fhalf_n` is always the inverse of `fhalf`.
- R8: In a cycle with `vco_tick` low, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high master reset, asynchronous |
| vco_tick | input | 1 | One-cycle enable, one per oscillator edge |
| div_sel | input | 2 | Divide code: N = 2^div_sel |
| fout | output | 1 | Main divided clock |
| fout_n | output | 1 | Complement of fout |
| fhalf | output | 1 | Half-rate clock |
| fhalf_n | output | 1 | Complement of fhalf |

## Verification
The hardest case to reach is a code change that lands in the middle of a run. It must be held off until the period closes, and it must not be confused with a change that lands exactly on a falling edge.

The stimulus waits until `fout` has just risen, or has just fallen, under a long code. It then switches the code one cycle later. Because ticks arrive every cycle at that point, the change is known to sit inside a run. The bench then expects the old run length for the rest of the period and the new length after that.

Run lengths are counted in ticks under steady, sparse and pseudo-random tick patterns. Resets are applied asynchronously in the middle of a high run.

// File: rtl/dual_rate_divider.sv
module dual_rate_divider #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vco_tick,
  input  logic [CODE_W-1:0] div_sel,
  output logic              fout,
  output logic              fout_n,
  output logic              fhalf,
  output logic              fhalf_n
);
  localparam int MAX_LOG = (1 << CODE_W) - 1;
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CODE_W-1:0] sel_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic              main_q;
  logic              half_q;
  logic              flip;

  assign last = CNT_W'((1 << sel_q) - 1);
  assign flip = vco_tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || (flip && main_q)) sel_q <= div_sel;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      main_q <= 1'b0;
      half_q <= 1'b0;
    end else if (flip) begin
      cnt    <= '0;
      main_q <= ~main_q;
      if (!main_q) half_q <= ~half_q;
    end else if (vco_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fout    = main_q;
  assign fout_n  = ~main_q;
  assign fhalf   = half_q;
  assign fhalf_n = ~half_q;
endmodule

// File: rtl/divider_check.sv
module divider_check #(
  parameter int CODE_W = 2
) (
  input logic clk,
  input logic rst,
  input logic vco_tick,
  input logic fout,
  input logic fout_n,
  input logic fhalf,
  input logic fhalf_n
);
  localparam int MAX_LOG = (1 << CODE_W) - 1;
  localparam int RUN_W   = MAX_LOG + 2;
  localparam int MAX_RUN = 1 << MAX_LOG;

  logic             fout_d, fhalf_d;
  logic [RUN_W-1:0] ticks, low_len;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fout_d  <= 1'b0;
      fhalf_d <= 1'b0;
      ticks   <= '0;
      low_len <= '0;
    end else begin
      fout_d  <= fout;
      fhalf_d <= fhalf;
      if (fout != fout_d) begin
        if (fout) low_len <= ticks;
        ticks <= vco_tick ? RUN_W'(1) : '0;
      end else if (vco_tick) begin
        ticks <= ticks + 1'b1;
      end
    end
  end

  assert_levels_in_reset_R4: assert property (@(posedge clk)
    rst |-> (!fout && fout_n && !fhalf && fhalf_n));

  assert_run_pow2_R1: assert property (@(posedge clk) disable iff (rst)
    (fout != fout_d) |-> (ticks != 0 && $onehot0(ticks) && ticks <= RUN_W'(MAX_RUN)));

  assert_even_duty_R3: assert property (@(posedge clk) disable iff (rst)
    (fout_d && !fout) |-> (ticks == low_len));

  assert_half_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (fhalf != fhalf_d) |-> (fout && !fout_d));

  assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !vco_tick |=> ($stable(fout) && $stable(fhalf)));
endmodule

bind dual_rate_divider divider_check #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_dual_rate_divider.sv
`timescale 1ns/1ps
module tb_dual_rate_divider;
  logic clk = 0, rst = 1, vco_tick = 0;
  logic [1:0] div_sel = 0;
  logic fout, fout_n, fhalf, fhalf_n;

  dual_rate_divider dut (.clk(clk), .rst(rst), .vco_tick(vco_tick), .div_sel(div_sel),
    .fout(fout), .fout_n(fout_n), .fhalf(fhalf), .fhalf_n(fhalf_n));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, mode = 0, cyc = 0;
  int run_ticks = 0, exp_half = 1, low_len = 0;
  logic [7:0] lfsr = 8'h5a;
  logic p_fout = 0, p_fhalf = 0;
  bit first_run = 1;
  string run_tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic observe();
    chk(fout_n == ~fout && fhalf_n == ~fhalf, "R7", {fout_n, fhalf_n}, {~fout, ~fhalf});
    if (rst) begin
      chk(!fout && !fhalf, "R4", {fout, fhalf}, 0);
      run_ticks = 0; p_fout = 0; p_fhalf = 0;
      exp_half = 1 << div_sel; first_run = 1;
      return;
    end
    if (vco_tick) run_ticks++;
    else chk(fout == p_fout && fhalf == p_fhalf, "R8", {fout, fhalf}, {p_fout, p_fhalf});
    if (fout != p_fout) begin
      chk(run_ticks == exp_half, first_run ? "R5" : run_tag, run_ticks, exp_half);
      first_run = 0;
      if (fout) begin
        low_len = run_ticks;
        chk(fhalf != p_fhalf, "R2", fhalf, !p_fhalf);
      end else begin
        chk(run_ticks == low_len, "R3", run_ticks, low_len);
        chk(fhalf == p_fhalf, "R2", fhalf, p_fhalf);
        exp_half = 1 << div_sel;
      end
      run_ticks = 0;
    end else if (fhalf != p_fhalf) begin
      chk(0, "R2", fhalf, p_fhalf);
    end
    p_fout = fout; p_fhalf = fhalf;
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (mode)
      0: vco_tick = 1'b1;
      1: vco_tick = (cyc % 3 == 0);
      default: vco_tick = lfsr[0];
    endcase
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_level(input logic lvl);
    for (int i = 0; i < 200 && fout != lvl; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    steps(4);
    chk(!fout && fout_n && !fhalf && fhalf_n, "R4", {fout, fout_n, fhalf, fhalf_n}, 4'b0101);
    for (int code = 0; code < 4; code++) begin
      for (int m = 0; m < 3; m++) begin
        wait_level(1'b1);
        rst = 1'b1;
        #1;
        chk(!fout && fout_n && !fhalf && fhalf_n, "R4", {fout, fout_n, fhalf, fhalf_n}, 4'b0101);
        steps(3);
        div_sel = code[1:0];
        mode = m;
        run_tag = "R1";
        steps(2);
        rst = 1'b0;
        steps(250);
      end
    end
    rst = 1'b1; mode = 0; div_sel = 2'd2;
    steps(3);
    rst = 1'b0;
    run_tag = "R6";
    wait_level(1'b1);
    step();
    div_sel = 2'd0;
    steps(40);
    div_sel = 2'd2;
    steps(40);
    wait_level(1'b1);
    wait_level(1'b0);
    step();
    div_sel = 2'd3;
    steps(100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule